// File: doc/BRIEF.md
# Rotating Multi-Bank Packet Buffer Controller

This block sits in front of a low-latency, multi-bank DRAM-style store and manages segments of packet data. Each request carries its full address in one cycle: a bank number and a row, each on its own dedicated line, with no separate row and column phase. A write request can take the next bank in a rotating order. The controller keeps one pointer for writes and another for reads. Each pointer starts at bank 0, counts up through bank 7 and then returns to bank 0. A request can also name a bank directly. Because the rotation moves on every access, a packet spread over consecutive segments can be written, and later read back, one segment per clock.

Each bank has a row-cycle lockout counter. While a bank is inside its lockout window, a request to it pulls `req_ready` low. The request is held in place and is not dropped. Because there is a single request port, no later request can get past it. Write data is sampled a fixed two cycles after the command is accepted. Read data comes back a fixed five cycles after acceptance, marked by a valid strobe. A behavioural storage array models the banks. A burst of `BURST` beats of `SEG_W` bits moves two beats per clock on a port of width `2*SEG_W`, so the default burst of two fills exactly one clock.

Top module: `rr_bank_buffer`

## Requirements
- R1: A rotated write (`req_write`=1, `req_explicit`=0) goes to the write pointer's bank. After reset that bank is 0. Each rotated write moves the pointer on by one, and after bank 7 it wraps to bank 0.
- R2: A rotated read (`req_write`=0, `req_explicit`=0) uses its own read pointer. The read pointer starts at bank 0, advances and wraps the same way as the write pointer, and is not affected by writes.
- R3: An explicit request (`req_explicit`=1) goes to the bank given on `req_bank` and leaves both rotation pointers unchanged.
- R4: For a write accepted in cycle c, `wr_data` is sampled in cycle c+WR_LAT, which is c+2 by default, and `wr_take` is high in exactly that cycle.
- R5: For a read accepted in cycle c, the data appears on `rd_data` in cycle c+RD_LAT, which is c+5 by default, and `rd_valid` is high in exactly the cycles that carry read data.
- R6: A bank is never accepted again within TRC cycles of its last acceptance (TRC is 8 by default). Until then, `req_ready` stays low for any request aimed at that bank.
- R7: A stalled request is held, not dropped. It is accepted in the first cycle its bank is free, which is exactly TRC cycles after the earlier access to that bank.
- R8: Eight rotated requests issued in consecutive cycles are all accepted without a stall. For reads, the data returns on eight consecutive cycles in bank order.
- R9: A read returns the data most recently written to the same bank and row.
- R10: After reset, `req_ready` is high, and `rd_valid` and `wr_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_explicit | input | 1 | 1 = use `req_bank`, 0 = use the rotation pointer |
| req_bank | input | $clog2(NUM_BANKS) | Target bank for explicit requests |
| req_row | input | ROW_W | Row within the bank |
| req_ready | output | 1 | The presented request is accepted this cycle when valid |
| wr_data | input | 2*SEG_W | Write beats, sampled WR_LAT cycles after acceptance |
| wr_take | output | 1 | High in the cycle that `wr_data` is sampled |
| rd_data | output | 2*SEG_W | Read beats |
| rd_valid | output | 1 | High in the cycle that `rd_data` carries read beats |

## Verification
The checker assumes that the requester holds a stalled request stable until it is accepted. It also assumes that write data arrives in the cycle the fixed latency names, and it does not model data that arrives late. The bench's driver task keeps to both rules. It keeps the request driven until `req_ready` is seen, and a separate process drives `wr_data` on the cycle computed from the acceptance cycle. The stimulus never issues explicit bank numbers above 7.

// File: rtl/rbc_pkg.sv
// Shared types and helpers for the rotating bank buffer controller.
package rbc_pkg;

    // Where a request takes its bank from.
    typedef enum logic {
        TGT_ROTATE   = 1'b0,
        TGT_EXPLICIT = 1'b1
    } tgt_sel_e;

    // Next position of a rotation pointer over n banks, wrapping to zero.
    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rbc_bank_timer.sv
// Per-bank row-cycle lockout.
// A hit loads that bank's counter so that the bank reads busy for the
// TRC-1 cycles after the access; it becomes free again TRC cycles after it.
// Assumes hit_bank < NUM_BANKS.
module rbc_bank_timer #(
    parameter int NUM_BANKS = 8,
    parameter int TRC       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit,
    input  logic [$clog2(NUM_BANKS)-1:0] hit_bank,
    output logic [NUM_BANKS-1:0]         busy
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CW     = $clog2(TRC + 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CW-1:0] cnt;

        // Load on access, count down to zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (hit && hit_bank == BANK_W'(b)) begin
                cnt <= CW'(TRC - 1);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign busy[b] = (cnt != '0);
    end
endmodule

// File: rtl/rbc_delay_pipe.sv
// Fixed-depth delay line for a valid flag and its payload.
// Assumes DEPTH >= 1. The payload carries no reset; only the valid flags do.
module rbc_delay_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    logic [DEPTH-1:0] vld;
    logic [WIDTH-1:0] dat [DEPTH];

    // Shift the valid flags one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                vld[i] <= vld[i-1];
            end
            vld[0] <= in_valid;
        end
    end

    // Shift the payload alongside the flags.
    always_ff @(posedge clk) begin
        for (int i = DEPTH - 1; i > 0; i--) begin
            dat[i] <= dat[i-1];
        end
        dat[0] <= in_data;
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];
endmodule

// File: rtl/rbc_burst_seq.sv
// Stretches one start pulse into LEN consecutive active cycles.
// Gives the beat-pair index for each active cycle and holds the address.
// Assumes a new start never arrives while a burst is still running.
module rbc_burst_seq #(
    parameter int AW  = 7,
    parameter int LEN = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [AW-1:0]                       start_addr,
    output logic                                active,
    output logic [((LEN > 1) ? $clog2(LEN) : 1)-1:0] beat,
    output logic [AW-1:0]                       addr
);
    localparam int BW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int RW = $clog2(LEN + 1);

    logic [RW-1:0] remain;
    logic [AW-1:0] addr_q;

    // Count the beat pairs still to come after the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= RW'(LEN - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Hold the address for the rest of the burst.
    always_ff @(posedge clk) begin
        if (start) begin
            addr_q <= start_addr;
        end
    end

    // Current beat index and address.
    always_comb begin
        active = start || (remain != '0);
        if (start) begin
            beat = '0;
            addr = start_addr;
        end else begin
            beat = BW'(LEN - int'(remain));
            addr = addr_q;
        end
    end
endmodule

// File: rtl/rbc_bank_store.sv
// Behavioural storage standing in for the DRAM banks.
// The address is {bank,row}. Each word holds one full burst and is
// written and read one slice (beat pair) at a time. Reads are registered.
module rbc_bank_store #(
    parameter int AW      = 7,
    parameter int WORD_W  = 32,
    parameter int SLICE_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [((WORD_W/SLICE_W > 1) ? $clog2(WORD_W/SLICE_W) : 1)-1:0] wslice,
    input  logic [SLICE_W-1:0]   wdata,
    input  logic                 re,
    input  logic [AW-1:0]        raddr,
    input  logic [((WORD_W/SLICE_W > 1) ? $clog2(WORD_W/SLICE_W) : 1)-1:0] rslice,
    output logic [SLICE_W-1:0]   rdata,
    output logic                 rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    // Write one slice of a word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr][int'(wslice)*SLICE_W +: SLICE_W] <= wdata;
        end
    end

    // Register the slice that is read.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr][int'(rslice)*SLICE_W +: SLICE_W];
        end
    end

    // Read strobe, one cycle behind the read enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
        end
    end
endmodule

// File: rtl/rr_bank_buffer.sv
// Rotating multi-bank packet buffer controller (top).
// Picks the target bank from the rotation pointers or from req_bank.
// Stalls requests to a bank that is still in its row cycle.
// Puts write and read data at fixed latencies after acceptance.
// Assumes: the requester holds a stalled request stable, req_bank < NUM_BANKS,
// RD_LAT >= 2, WR_LAT >= 1, BURST even.
module rr_bank_buffer #(
    parameter int NUM_BANKS = 8,
    parameter int SEG_W     = 16,
    parameter int BURST     = 2,
    parameter int ROW_W     = 4,
    parameter int RD_LAT    = 5,
    parameter int WR_LAT    = 2,
    parameter int TRC       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_explicit,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]             req_row,
    output logic                         req_ready,
    input  logic [2*SEG_W-1:0]           wr_data,
    output logic                         wr_take,
    output logic [2*SEG_W-1:0]           rd_data,
    output logic                         rd_valid
);
    import rbc_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LEN    = BURST / 2;
    localparam int PORT_W = 2 * SEG_W;
    localparam int WORD_W = SEG_W * BURST;
    localparam int AW     = BANK_W + ROW_W;
    localparam int BEAT_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int GAP_W  = $clog2(LEN + 1);

    tgt_sel_e             tgt_sel;
    logic [BANK_W-1:0]    wr_ptr, rd_ptr, tgt_bank;
    logic [NUM_BANKS-1:0] busy;
    logic [GAP_W-1:0]     gap_cnt;
    logic                 accept, acc_wr, acc_rd;

    logic                 wp_valid, rp_valid;
    logic [AW-1:0]        wp_addr, rp_addr;
    logic                 ws_active, rs_active;
    logic [BEAT_W-1:0]    ws_beat, rs_beat;
    logic [AW-1:0]        ws_addr, rs_addr;

    // Choose the bank the presented request targets.
    always_comb begin
        tgt_sel = tgt_sel_e'(req_explicit);
        case (tgt_sel)
            TGT_EXPLICIT: tgt_bank = req_bank;
            default:      tgt_bank = req_write ? wr_ptr : rd_ptr;
        endcase
    end

    assign req_ready = (gap_cnt == '0) && !busy[tgt_bank];
    assign accept    = req_valid && req_ready;
    assign acc_wr    = accept && req_write;
    assign acc_rd    = accept && !req_write;

    // Move the matching rotation pointer on each accepted rotated request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (accept && tgt_sel == TGT_ROTATE) begin
            if (req_write) begin
                wr_ptr <= BANK_W'(wrap_next(int'(wr_ptr), NUM_BANKS));
            end else begin
                rd_ptr <= BANK_W'(wrap_next(int'(rd_ptr), NUM_BANKS));
            end
        end
    end

    // Keep commands one burst apart so that data beats never overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (accept) begin
            gap_cnt <= GAP_W'(LEN - 1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    rbc_bank_timer #(.NUM_BANKS(NUM_BANKS), .TRC(TRC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (accept),
        .hit_bank (tgt_bank),
        .busy     (busy)
    );

    // Write path: the command waits WR_LAT cycles for its data.
    rbc_delay_pipe #(.WIDTH(AW), .DEPTH(WR_LAT)) u_wr_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_wr),
        .in_data   ({tgt_bank, req_row}),
        .out_valid (wp_valid),
        .out_data  (wp_addr)
    );

    rbc_burst_seq #(.AW(AW), .LEN(LEN)) u_wr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wp_valid),
        .start_addr (wp_addr),
        .active     (ws_active),
        .beat       (ws_beat),
        .addr       (ws_addr)
    );

    // Read path: one stage less, because the store registers its output.
    rbc_delay_pipe #(.WIDTH(AW), .DEPTH(RD_LAT - 1)) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_rd),
        .in_data   ({tgt_bank, req_row}),
        .out_valid (rp_valid),
        .out_data  (rp_addr)
    );

    rbc_burst_seq #(.AW(AW), .LEN(LEN)) u_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rp_valid),
        .start_addr (rp_addr),
        .active     (rs_active),
        .beat       (rs_beat),
        .addr       (rs_addr)
    );

    rbc_bank_store #(.AW(AW), .WORD_W(WORD_W), .SLICE_W(PORT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ws_active),
        .waddr  (ws_addr),
        .wslice (ws_beat),
        .wdata  (wr_data),
        .re     (rs_active),
        .raddr  (rs_addr),
        .rslice (rs_beat),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    assign wr_take = ws_active;
endmodule

// File: rtl/rr_bank_buffer_chk.sv
// Checker for rr_bank_buffer, bound to every instance.
// It keeps its own models of the bank ages, the rotation pointers and the
// expected data strobes, and compares them with the block's behaviour.
module rr_bank_buffer_chk #(
    parameter int NUM_BANKS = 8,
    parameter int TRC       = 8,
    parameter int RD_LAT    = 5,
    parameter int WR_LAT    = 2,
    parameter int LEN       = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         accept,
    input logic                         req_write,
    input logic                         req_explicit,
    input logic [$clog2(NUM_BANKS)-1:0] tgt_bank,
    input logic                         wr_take,
    input logic                         rd_valid
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int AGE_W  = $clog2(TRC + 1);
    localparam int WH     = WR_LAT + LEN - 1;
    localparam int RH     = RD_LAT + LEN - 1;

    logic [AGE_W-1:0]  age [NUM_BANKS];
    logic [BANK_W-1:0] wptr_m, rptr_m;
    logic [WH-1:0]     hist_w;
    logic [RH-1:0]     hist_r;
    logic              exp_take, exp_rvalid;

    // Cycles since each bank's last access, saturating at TRC.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!rst_n) begin
                age[b] <= AGE_W'(TRC);
            end else if (accept && tgt_bank == BANK_W'(b)) begin
                age[b] <= AGE_W'(1);
            end else if (int'(age[b]) < TRC) begin
                age[b] <= age[b] + 1'b1;
            end
        end
    end

    // Model of the rotation pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_m <= '0;
            rptr_m <= '0;
        end else if (accept && !req_explicit) begin
            if (req_write) begin
                wptr_m <= (int'(wptr_m) == NUM_BANKS - 1) ? '0 : wptr_m + 1'b1;
            end else begin
                rptr_m <= (int'(rptr_m) == NUM_BANKS - 1) ? '0 : rptr_m + 1'b1;
            end
        end
    end

    // History of accepted writes and reads, one bit per past cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_w <= '0;
            hist_r <= '0;
        end else begin
            for (int i = WH - 1; i > 0; i--) hist_w[i] <= hist_w[i-1];
            for (int i = RH - 1; i > 0; i--) hist_r[i] <= hist_r[i-1];
            hist_w[0] <= accept && req_write;
            hist_r[0] <= accept && !req_write;
        end
    end

    // Which cycles should carry data beats.
    always_comb begin
        exp_take   = |hist_w[WH-1:WR_LAT-1];
        exp_rvalid = |hist_r[RH-1:RD_LAT-1];
    end

    assert_bank_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(age[tgt_bank]) >= TRC));

    assert_rot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && !req_explicit) |-> (tgt_bank == wptr_m));

    assert_rot_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && !req_explicit) |-> (tgt_bank == rptr_m));

    assert_write_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take == exp_take);

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == exp_rvalid);
endmodule

bind rr_bank_buffer rr_bank_buffer_chk #(
    .NUM_BANKS (NUM_BANKS),
    .TRC       (TRC),
    .RD_LAT    (RD_LAT),
    .WR_LAT    (WR_LAT),
    .LEN       (BURST / 2)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_write    (req_write),
    .req_explicit (req_explicit),
    .tgt_bank     (tgt_bank),
    .wr_take      (wr_take),
    .rd_valid     (rd_valid)
);

// File: tb/rr_bank_buffer_tb_top.sv
// Scoreboard bench for rr_bank_buffer, using the default parameters.
module rr_bank_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB     = 8;
    localparam int SEG_W  = 16;
    localparam int ROW_W  = 4;
    localparam int RD_LAT = 5;
    localparam int WR_LAT = 2;
    localparam int TRC    = 8;
    localparam int DW     = 2 * SEG_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_explicit = 1'b0;
    logic [2:0]    req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic          req_ready;
    logic [DW-1:0] wr_data = '0;
    logic          wr_take;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    rr_bank_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_explicit(req_explicit), .req_bank(req_bank), .req_row(req_row),
        .req_ready(req_ready), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    int wq_cyc[$];  logic [DW-1:0] wq_dat[$];
    int rq_cyc[$];  logic [DW-1:0] rq_dat[$];
    logic [DW-1:0] exp_mem [NB][1 << ROW_W];
    int m_wptr = 0, m_rptr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: present a request, hold it until accepted, push what is expected.
    task automatic issue(input bit wr, input bit expl, input int bank, input int row,
                         input logic [DW-1:0] data, output int acc, output int stalls);
        int b;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_explicit = expl;
        req_bank = 3'(bank); req_row = ROW_W'(row);
        #1;
        stalls = 0;
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        acc = cyc;
        b = expl ? bank : (wr ? m_wptr : m_rptr);
        if (!expl) begin
            if (wr) m_wptr = (m_wptr + 1) % NB;
            else    m_rptr = (m_rptr + 1) % NB;
        end
        if (wr) begin
            exp_mem[b][row] = data;
            wq_cyc.push_back(acc + WR_LAT); wq_dat.push_back(data);
        end else begin
            rq_cyc.push_back(acc + RD_LAT); rq_dat.push_back(exp_mem[b][row]);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Write-data driver and wr_take monitor (R4).
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_t;
            while (wq_cyc.size() > 0 && wq_cyc[0] < cyc) begin
                check(1'b0, "R4", "write data slot passed unsampled", cyc, wq_cyc[0]);
                void'(wq_cyc.pop_front()); void'(wq_dat.pop_front());
            end
            exp_t = (wq_cyc.size() > 0 && wq_cyc[0] == cyc);
            if (exp_t) begin
                wr_data = wq_dat.pop_front();
                void'(wq_cyc.pop_front());
            end
            if (exp_t || wr_take) check(wr_take == exp_t, "R4", "wr_take", wr_take, exp_t);
        end
    end

    // Read monitor: cycle (R5, R8) and data (R9) of every returned beat.
    always @(negedge clk) begin
        if (rst_n) begin
            while (rq_cyc.size() > 0 && rq_cyc[0] < cyc) begin
                check(1'b0, "R5", "read data missing in cycle", cyc, rq_cyc[0]);
                void'(rq_cyc.pop_front()); void'(rq_dat.pop_front());
            end
            if (rd_valid) begin
                if (rq_cyc.size() == 0) begin
                    check(1'b0, "R5", "unexpected rd_valid", 1, 0);
                end else begin
                    check(rq_cyc[0] == cyc, "R5", "read data cycle", cyc, rq_cyc[0]);
                    check(rd_data == rq_dat[0], "R9", "read data", rd_data, rq_dat[0]);
                    void'(rq_cyc.pop_front()); void'(rq_dat.pop_front());
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", cyc, 20000);
        finish_run();
    end

    initial begin
        int acc, st, prev;
        int first_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10: idle state after reset
        check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
        check(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
        check(wr_take == 1'b0, "R10", "wr_take after reset", wr_take, 0);

        // R1, R8: rotated write sweep, one per clock with no stall
        for (int i = 0; i < NB; i++) begin
            issue(1'b1, 1'b0, 0, 2, DW'(32'hA000 + i), acc, st);
            if (i == 0) first_w = acc;
            check(st == 0, "R8", "write sweep stall", st, 0);
        end
        // R2, R8: rotated read sweep starts exactly TRC after the first write
        for (int i = 0; i < NB; i++) begin
            issue(1'b0, 1'b0, 0, 2, '0, acc, st);
            check(st == 0, "R8", "read sweep stall", st, 0);
            if (i == 0) check(acc - first_w == TRC, "R6", "bank 0 reuse distance", acc - first_w, TRC);
            else        check(acc - prev == 1, "R8", "read sweep spacing", acc - prev, 1);
            prev = acc;
        end
        idle(12);

        // R3: an explicit write leaves the write pointer alone (next rotated goes to bank 0)
        issue(1'b1, 1'b1, 6, 9, DW'(32'hB006), acc, st);
        issue(1'b1, 1'b0, 0, 9, DW'(32'hB100), acc, st);
        issue(1'b0, 1'b1, 0, 9, '0, acc, st);  // R3/R1: bank 0 row 9 holds B100
        issue(1'b0, 1'b1, 6, 9, '0, acc, st);  // R3: bank 6 row 9 holds B006
        issue(1'b0, 1'b0, 0, 9, '0, acc, st);  // R2: read pointer wrapped to bank 0
        idle(12);

        // R6, R7: a stalled request is held and accepted exactly TRC later
        issue(1'b1, 1'b1, 3, 1, DW'(32'hC303), prev, st);
        issue(1'b0, 1'b1, 3, 1, '0, acc, st);
        check(st == TRC - 1, "R6", "stall cycles on busy bank", st, TRC - 1);
        check(acc - prev == TRC, "R7", "acceptance after stall", acc - prev, TRC);
        idle(12);

        // R9: independent rows and banks keep their own data
        issue(1'b1, 1'b1, 5, 0,  DW'(32'hD500), acc, st);
        issue(1'b1, 1'b1, 4, 0,  DW'(32'hD400), acc, st);
        issue(1'b1, 1'b1, 5, 15, DW'(32'hD50F), acc, st);
        issue(1'b0, 1'b1, 4, 0,  '0, acc, st);
        issue(1'b0, 1'b1, 5, 0,  '0, acc, st);
        issue(1'b0, 1'b1, 5, 15, '0, acc, st);
        idle(20);

        check(rq_cyc.size() == 0, "R5", "reads outstanding at end", rq_cyc.size(), 0);
        check(wq_cyc.size() == 0, "R4", "writes outstanding at end", wq_cyc.size(), 0);
        finish_run();
    end
endmodule